// File: doc/BRIEF.md
# Control Register Bank with Mirrored Readback

This block holds the control registers that a CPU programs over a simple synchronous bus. Every writable register lives in flip-flops, because its value drives downstream logic on every cycle; the registers come out as one flat vector. Readback does not pass through a wide multiplexer over all of these flip-flops. Instead, a single-port synchronous RAM takes a copy of every CPU write, and a read of an ordinary read-write register returns that copy.

Two kinds of register cannot be served from the copy. Read-only status words come from hardware inputs. Hardware-modified registers can be reloaded by logic without a CPU write. A fixed per-address attribute table marks each of these, and a small dedicated multiplexer returns their live value instead. The copy could disagree with the registers only after reset. To prevent this, the control logic walks the RAM for one pass after reset and writes each register's reset value into it. Software must leave the bus idle for `2**ADDR_W` cycles after reset is released.

Top module: `regbank_shadow`

## Requirements
- R1: While reset is held, every read-write and hardware-modified lane of `regOut` equals its reset value, which is `(RST_BASE + 17*index) mod 2**DATA_W`. Every read-only lane is zero, and `busRdValid` is low.
- R2: A bus write to a read-write or hardware-modified address updates that lane of `regOut` at the next clock edge. All other lanes keep their values.
- R3: Once an idle period of `2**ADDR_W` cycles has followed reset, a read of a read-write register returns the data of the last bus write to that address.
- R4: Once the same idle period has followed reset, a read of a read-write register that has never been written returns its reset value from R1.
- R5: `busRdValid` is high in the cycle after `busRdEn` is high, and low in the cycle after `busRdEn` is low. The read data is valid in that same cycle, and this timing is the same for every register kind.
- R6: A read of a read-only address returns the `statusIn` lane of that address as it stood in the cycle of `busRdEn`. A bus write to a read-only address has no effect: its `regOut` lane stays zero and readback still returns `statusIn`.
- R7: A read of a hardware-modified address returns the current register value. This includes a value loaded through `hwLoad`/`hwData`, rather than the last bus write.
- R8: When `hwLoad` and a bus write target the same hardware-modified register in one cycle, the hardware value is the one stored.
- R9: A read and a write to the same address in one cycle return the value held before the write. The next read returns the new value.
- R10: With default parameters, addresses 6 and 15 are read-only and addresses 5 and 8 are hardware-modified. All other addresses are read-write. If an address is marked both read-only and hardware-modified, read-only takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address for both read and write |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W | Read data, valid with busRdValid |
| busRdValid | output | 1 | High one cycle after busRdEn |
| hwLoad | input | 2**ADDR_W | Per-register hardware load strobe (hardware-modified lanes only) |
| hwData | input | 2**ADDR_W*DATA_W | Hardware load values, lane i at bits [i*DATA_W +: DATA_W] |
| statusIn | input | 2**ADDR_W*DATA_W | Status words for read-only addresses, same lane layout |
| regOut | output | 2**ADDR_W*DATA_W | Flat register outputs, same lane layout |

## Verification
The checker verifies four properties on every cycle:
- the one-cycle valid timing;
- the update of a lane after a qualified write;
- hardware-load priority;
- lane stability without a write, and the live-value return of read-only and hardware-modified reads.

The checker has no model of the mirror RAM, so it cannot check readback of read-write registers. This covers the post-reset contents, the last-written value and the old-value result of a read during a write. Only the bench's reference model, driven through the written and unwritten scenarios, shows those.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [1:0] {
    KIND_RW = 2'd0,
    KIND_RO = 2'd1,
    KIND_HW = 2'd2
  } regKind_e;

  // Strobes from control to datapath for the current bus cycle
  typedef struct packed {
    logic ramWe;
    logic ramRe;
    logic regWe;
    logic rdLaunch;
    logic bypassSel;
    logic bypassRo;
  } bankStrobe_t;

  // Attribute table entry: read-only wins over hardware-modified
  function automatic regKind_e kindOf(int idx, logic [63:0] roMask, logic [63:0] hwMask);
    if (roMask[idx])      return KIND_RO;
    else if (hwMask[idx]) return KIND_HW;
    else                  return KIND_RW;
  endfunction

  function automatic logic [63:0] resetWord(int idx, logic [63:0] base);
    return base + 64'(idx) * 64'd17;
  endfunction

endpackage

// File: rtl/regbank_ram.sv
module regbank_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single port: a same-cycle write is seen by the next read
  always_ff @(posedge clk) begin
    if (en) begin
      rData <= mem[addr];
      if (we) mem[addr] <= wData;
    end
  end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int                     ADDR_W   = 4,
  parameter int                     DATA_W   = 16,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK  = '0,
  parameter logic [(1<<ADDR_W)-1:0] HW_MASK  = '0,
  parameter logic [DATA_W-1:0]      RST_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output bankStrobe_t       strb,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWData,
  output logic              rdValidQ,
  output logic              rdSelQ
);
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

  regKind_e          addrKind;
  logic              initActive;
  logic [ADDR_W-1:0] initCnt;
  logic [DATA_W-1:0] sweepWord;

  always_comb addrKind = kindOf(int'(busAddr), 64'(RO_MASK), 64'(HW_MASK));

  always_comb sweepWord = DATA_W'(resetWord(int'(initCnt), 64'(RST_BASE)));

  // Post-reset pass that fills the mirror with reset values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initActive <= 1'b1;
      initCnt    <= '0;
    end else if (initActive) begin
      initCnt <= initCnt + 1'b1;
      if (initCnt == LAST_IDX) initActive <= 1'b0;
    end
  end

  always_comb begin
    strb.ramWe     = initActive | busWrEn;
    strb.ramRe     = ~initActive & busRdEn;
    strb.regWe     = ~initActive & busWrEn & (addrKind != KIND_RO);
    strb.rdLaunch  = busRdEn;
    strb.bypassSel = addrKind != KIND_RW;
    strb.bypassRo  = addrKind == KIND_RO;
    ramAddr        = initActive ? initCnt : busAddr;
    ramWData       = initActive ? sweepWord : busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdSelQ   <= 1'b0;
    end else begin
      rdValidQ <= busRdEn;
      if (busRdEn) rdSelQ <= strb.bypassSel;
    end
  end
endmodule

// File: rtl/regbank_dpath.sv
module regbank_dpath
  import regbank_pkg::*;
#(
  parameter int                     ADDR_W   = 4,
  parameter int                     DATA_W   = 16,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK  = '0,
  parameter logic [(1<<ADDR_W)-1:0] HW_MASK  = '0,
  parameter logic [DATA_W-1:0]      RST_BASE = '0
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWrData,
  input  bankStrobe_t                      strb,
  input  logic                             rdSelQ,
  input  logic [(1<<ADDR_W)-1:0]           hwLoad,
  input  logic [(1<<ADDR_W)*DATA_W-1:0]    hwData,
  input  logic [(1<<ADDR_W)*DATA_W-1:0]    statusIn,
  input  logic [DATA_W-1:0]                ramQ,
  output logic [(1<<ADDR_W)*DATA_W-1:0]    regOut,
  output logic [DATA_W-1:0]                busRdData
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] hwVal;
  logic [DATA_W-1:0] bypassVal;
  logic [DATA_W-1:0] bypassQ;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
    localparam regKind_e LANE_KIND = kindOf(g, 64'(RO_MASK), 64'(HW_MASK));
    localparam logic [DATA_W-1:0] LANE_RST = DATA_W'(resetWord(g, 64'(RST_BASE)));

    if (LANE_KIND == KIND_RO) begin : g_ro
      logic unusedLane;
      assign unusedLane = ^{hwLoad[g], hwData[g*DATA_W +: DATA_W]};
      assign regOut[g*DATA_W +: DATA_W] = '0;
    end else if (LANE_KIND == KIND_HW) begin : g_hw
      logic [DATA_W-1:0] laneQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                     laneQ <= LANE_RST;
        else if (hwLoad[g])                            laneQ <= hwData[g*DATA_W +: DATA_W];
        else if (strb.regWe && busAddr == ADDR_W'(g))  laneQ <= busWrData;
      end
      assign regOut[g*DATA_W +: DATA_W] = laneQ;
    end else begin : g_rw
      logic [DATA_W-1:0] laneQ;
      logic unusedLane;
      assign unusedLane = ^{hwLoad[g], hwData[g*DATA_W +: DATA_W]};
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                     laneQ <= LANE_RST;
        else if (strb.regWe && busAddr == ADDR_W'(g))  laneQ <= busWrData;
      end
      assign regOut[g*DATA_W +: DATA_W] = laneQ;
    end
  end

  // Reduced mux: only hardware-modified lanes take part
  always_comb begin
    hwVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (kindOf(i, 64'(RO_MASK), 64'(HW_MASK)) == KIND_HW && busAddr == ADDR_W'(i))
        hwVal = regOut[i*DATA_W +: DATA_W];
    end
  end

  always_comb bypassVal = strb.bypassRo ? statusIn[busAddr*DATA_W +: DATA_W] : hwVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               bypassQ <= '0;
    else if (strb.rdLaunch && strb.bypassSel) bypassQ <= bypassVal;
  end

  assign busRdData = rdSelQ ? bypassQ : ramQ;
endmodule

// File: rtl/regbank_shadow.sv
module regbank_shadow
  import regbank_pkg::*;
#(
  parameter int                     ADDR_W   = 4,
  parameter int                     DATA_W   = 16,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK  = (1<<ADDR_W)'(16'h8040),
  parameter logic [(1<<ADDR_W)-1:0] HW_MASK  = (1<<ADDR_W)'(16'h0120),
  parameter logic [DATA_W-1:0]      RST_BASE = DATA_W'(16'h1000)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWrEn,
  input  logic [DATA_W-1:0]             busWrData,
  input  logic                          busRdEn,
  output logic [DATA_W-1:0]             busRdData,
  output logic                          busRdValid,
  input  logic [(1<<ADDR_W)-1:0]        hwLoad,
  input  logic [(1<<ADDR_W)*DATA_W-1:0] hwData,
  input  logic [(1<<ADDR_W)*DATA_W-1:0] statusIn,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regOut
);
  bankStrobe_t       strb;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWData;
  logic [DATA_W-1:0] ramQ;
  logic              rdSelQ;

  regbank_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RO_MASK(RO_MASK),
    .HW_MASK(HW_MASK), .RST_BASE(RST_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .strb(strb),
    .ramAddr(ramAddr), .ramWData(ramWData), .rdValidQ(busRdValid),
    .rdSelQ(rdSelQ)
  );

  regbank_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .en(strb.ramWe | strb.ramRe), .we(strb.ramWe),
    .addr(ramAddr), .wData(ramWData), .rData(ramQ)
  );

  regbank_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RO_MASK(RO_MASK),
    .HW_MASK(HW_MASK), .RST_BASE(RST_BASE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .strb(strb), .rdSelQ(rdSelQ), .hwLoad(hwLoad), .hwData(hwData),
    .statusIn(statusIn), .ramQ(ramQ), .regOut(regOut), .busRdData(busRdData)
  );
endmodule

// File: rtl/regbank_shadow_chk.sv
module regbank_shadow_chk
  import regbank_pkg::*;
#(
  parameter int                     ADDR_W   = 4,
  parameter int                     DATA_W   = 16,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK  = '0,
  parameter logic [(1<<ADDR_W)-1:0] HW_MASK  = '0,
  parameter logic [DATA_W-1:0]      RST_BASE = '0
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             busAddr,
  input logic                          busWrEn,
  input logic [DATA_W-1:0]             busWrData,
  input logic                          busRdEn,
  input logic [DATA_W-1:0]             busRdData,
  input logic                          busRdValid,
  input logic [(1<<ADDR_W)-1:0]        hwLoad,
  input logic [(1<<ADDR_W)*DATA_W-1:0] hwData,
  input logic [(1<<ADDR_W)*DATA_W-1:0] statusIn,
  input logic [(1<<ADDR_W)*DATA_W-1:0] regOut
);
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0]  sinceRst;
  logic              initDone;
  regKind_e          kindNow;
  logic              wrQual;
  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-1:0] lastData;
  logic [DATA_W-1:0] statusAtAddr;
  logic [DATA_W-1:0] regAtAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              sinceRst <= '0;
    else if (sinceRst != CNT_W'(NUM_REGS))  sinceRst <= sinceRst + 1'b1;
  end

  always_ff @(posedge clk) begin
    lastAddr <= busAddr;
    lastData <= busWrData;
  end

  always_comb begin
    initDone     = sinceRst == CNT_W'(NUM_REGS);
    kindNow      = kindOf(int'(busAddr), 64'(RO_MASK), 64'(HW_MASK));
    wrQual       = busWrEn && initDone && kindNow != KIND_RO &&
                   !(kindNow == KIND_HW && hwLoad[busAddr]);
    statusAtAddr = statusIn[busAddr*DATA_W +: DATA_W];
    regAtAddr    = regOut[busAddr*DATA_W +: DATA_W];
  end

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);
  assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid);
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrQual |=> regOut[lastAddr*DATA_W +: DATA_W] == lastData);
  assert_ro_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && kindNow == KIND_RO) |=> busRdData == $past(statusAtAddr));
  assert_hw_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && kindNow == KIND_HW) |=> busRdData == $past(regAtAddr));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_lane_chk
    localparam regKind_e LK = kindOf(k, 64'(RO_MASK), 64'(HW_MASK));
    if (LK == KIND_HW) begin : g_hw
      assert_hw_priority_R8: assert property (@(posedge clk) disable iff (!rstN)
        hwLoad[k] |=> regOut[k*DATA_W +: DATA_W] == $past(hwData[k*DATA_W +: DATA_W]));
    end else if (LK == KIND_RW) begin : g_rw
      assert_lane_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
        !(busWrEn && busAddr == ADDR_W'(k)) |=> $stable(regOut[k*DATA_W +: DATA_W]));
    end else begin : g_ro
      assert_ro_write_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
        (busWrEn && busAddr == ADDR_W'(k)) |=> regOut[k*DATA_W +: DATA_W] == '0);
    end
  end
endmodule

bind regbank_shadow regbank_shadow_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RO_MASK(RO_MASK),
  .HW_MASK(HW_MASK), .RST_BASE(RST_BASE)
) u_chk (.*);

// File: tb/regbank_shadow_bench.sv
`timescale 1ns/1ps
module regbank_shadow_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NR = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [AW-1:0]        busAddr = '0;
  logic                 busWrEn = 1'b0;
  logic [DW-1:0]        busWrData = '0;
  logic                 busRdEn = 1'b0;
  logic [DW-1:0]        busRdData;
  logic                 busRdValid;
  logic [NR-1:0]        hwLoad = '0;
  logic [NR*DW-1:0]     hwData = '0;
  logic [NR*DW-1:0]     statusIn = '0;
  logic [NR*DW-1:0]     regOut;

  regbank_shadow u_regbank_shadow (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .busRdValid(busRdValid), .hwLoad(hwLoad), .hwData(hwData),
    .statusIn(statusIn), .regOut(regOut)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";

  logic [DW-1:0] mReg [NR];
  logic [DW-1:0] mMirror [NR];
  logic          expValid = 1'b0;
  logic [DW-1:0] expData = '0;

  // R10 attribute map: 0 read-write, 1 read-only, 2 hardware-modified
  function automatic int kindB(int i);
    if (i == 6 || i == 15) return 1;
    if (i == 5 || i == 8)  return 2;
    return 0;
  endfunction

  function automatic logic [DW-1:0] rstB(int i);
    return DW'(32'h1000 + i * 17);
  endfunction

  function automatic logic [NR*DW-1:0] expOut();
    logic [NR*DW-1:0] v = '0;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = (kindB(i) == 1) ? '0 : mReg[i];
    return v;
  endfunction

  task automatic check(bit ok, string what, logic [NR*DW-1:0] act, logic [NR*DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(regOut === expOut(), "regOut", regOut, expOut());
    check(busRdValid === expValid, "busRdValid", NR*DW'(busRdValid), NR*DW'(expValid));
    if (expValid)
      check(busRdData === expData, "busRdData", NR*DW'(busRdData), NR*DW'(expData));
  endtask

  // One clock: update model from the driven inputs, then compare at negedge
  task automatic tick();
    int a = int'(busAddr);
    logic          nv = busRdEn;
    logic [DW-1:0] nd = '0;
    if (busRdEn) begin
      case (kindB(a))
        1:       nd = statusIn[a*DW +: DW];
        2:       nd = mReg[a];
        default: nd = mMirror[a];
      endcase
    end
    if (busWrEn) begin
      mMirror[a] = busWrData;
      if (kindB(a) != 1) mReg[a] = busWrData;
    end
    for (int k = 0; k < NR; k++)
      if (kindB(k) == 2 && hwLoad[k]) mReg[k] = hwData[k*DW +: DW];
    @(posedge clk);
    expValid = nv;
    expData  = nd;
    @(negedge clk);
    compareAll();
  endtask

  task automatic busOp(bit wr, bit rd, int addr, logic [DW-1:0] data);
    busAddr = AW'(addr); busWrEn = wr; busRdEn = rd; busWrData = data;
    tick();
    busWrEn = 1'b0; busRdEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mReg[i] = rstB(i); mMirror[i] = rstB(i); end
    // R1: reset values on regOut, valid low
    curReq = "R1";
    repeat (3) @(negedge clk);
    compareAll();
    rstN = 1'b1;
    idle(NR + 2);

    // R4: unwritten read-write registers read their reset values
    curReq = "R4";
    busOp(0, 1, 0, '0);
    busOp(0, 1, 3, '0);
    busOp(0, 1, 14, '0);
    idle(1);

    // R2 / R3: writes land on regOut and read back from the mirror
    curReq = "R2";
    busOp(1, 0, 2, 16'hBEEF);
    busOp(1, 0, 10, 16'h1234);
    curReq = "R3";
    busOp(0, 1, 2, '0);
    busOp(0, 1, 10, '0);
    for (int i = 0; i < NR; i++) if (kindB(i) == 0) busOp(1, 0, i, DW'(16'hA000 + i * 3));
    for (int i = 0; i < NR; i++) if (kindB(i) == 0) busOp(0, 1, i, '0);
    idle(1);

    // R9: read and write in one cycle returns the old value
    curReq = "R9";
    busOp(1, 1, 2, 16'h5555);
    busOp(0, 1, 2, '0);
    idle(1);

    // R6: read-only lanes follow statusIn, writes to them are ignored
    curReq = "R6";
    statusIn[6*DW +: DW] = 16'hCAFE;
    statusIn[15*DW +: DW] = 16'h0BAD;
    busOp(0, 1, 6, '0);
    busOp(1, 0, 6, 16'hFFFF);
    busOp(0, 1, 6, '0);
    statusIn[6*DW +: DW] = 16'h0F0F;
    busOp(0, 1, 6, '0);
    busOp(0, 1, 15, '0);

    // R7: hardware load overrides the last bus write in readback
    curReq = "R7";
    busOp(1, 0, 5, 16'h1111);
    busOp(0, 1, 5, '0);
    hwData[5*DW +: DW] = 16'h2222; hwLoad[5] = 1'b1;
    tick();
    hwLoad[5] = 1'b0;
    busOp(0, 1, 5, '0);

    // R8: hardware wins a same-cycle collision
    curReq = "R8";
    hwData[8*DW +: DW] = 16'h7777; hwLoad[8] = 1'b1;
    busOp(1, 0, 8, 16'hAAAA);
    hwLoad[8] = 1'b0;
    busOp(0, 1, 8, '0);

    // R5: back-to-back reads across kinds, then gaps
    curReq = "R5";
    busOp(0, 1, 6, '0);
    busOp(0, 1, 8, '0);
    busOp(0, 1, 9, '0);
    busOp(0, 1, 15, '0);
    idle(2);
    busOp(0, 1, 4, '0);
    idle(1);

    // R10: classification at the boundaries of the map
    curReq = "R10";
    busOp(1, 0, 15, 16'h3333);
    busOp(0, 1, 15, '0);
    busOp(1, 0, 9, 16'h4444);
    busOp(0, 1, 9, '0);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule